// File: doc/BRIEF.md
# Status Ring Producer with Wrap Tag

This block turns each completed command into a fixed 25-word status record. It writes the record into a circular ring in memory, one word per memory handshake, and then pulses an interrupt. The command engine sends a completion through a valid/ready handshake that carries the command number and a 2-bit result code. A separate start strobe marks the moment execution begins. The block measures execution time in microseconds from that strobe until the completion is accepted. The time spent queued before the strobe is not counted.

The last word of every record carries a 4-bit wrap tag. The tag counts how many times the producer has gone around the ring. A consumer can tell a fresh record from a stale one by the tag's least significant bit, so it never has to read the head pointer. The block contains a small consumer-side tag checker that does exactly this:
- It keeps its own read pointer and an expected-bit flag.
- The flag flips each time the read pointer wraps.
- A record is fresh when its tag LSB equals the flag.

Software must fill the ring before first use so that every tag LSB reads 1.

Handshake rules:
- **Completion handshake.** `cpl_ready` is high only while no record is being written. A completion held with `cpl_valid` while `cpl_ready` is low waits, and nothing is captured.
- **Memory handshake.** `mem_valid` stays high for all 25 words of a record. While `mem_ready` is low, `mem_addr` and `mem_wdata` hold their values. A word counts as written on a cycle where both are high.

Top module: `status_ring_producer`

## Requirements
- R1: A record is 25 words. Word i is written to address BASE_ADDR + head*25 + i, in increasing order of i. Words 2 to 23 are zero.
- R2: Word 0 has this layout: [15:0] is the command number, [25:16] is the duration, [27:26] is the result code passed through unchanged (0 success, 1 blocked, 2 failed, 3 resource blocked), and [31:28] is zero.
- R3: Let D be the number of clock edges from the edge that samples `exec_start` to the edge that accepts the completion. The duration is floor((D-1)/CYC_PER_US), saturating at 1023.
- R4: Word 1 equals `time_now` as sampled on the edge where word 0 is accepted by memory.
- R5: Word 24 has the wrap tag in [31:28] and zero in [27:0]. The tag is 0 after reset and increases by one, modulo 16, when the head pointer wraps to 0.
- R6: The head pointer advances by one when a record's last word is accepted. It wraps from RING_ENTRIES-1 to 0.
- R7: `irq` is high for exactly one cycle, the cycle after the last word of a record is accepted.
- R8: From the accepting edge until the last word is written, `cpl_ready` is low. During this time `mem_valid` is high, and `mem_addr` and `mem_wdata` hold while `mem_ready` is low.
- R9: After reset: `cpl_ready` is 1, `mem_valid` is 0, `irq` is 0, the head pointer is 0, and the consumer read pointer is 0.
- R10: The checker reports `cons_fresh` when `cons_tag_lsb` equals its expected bit. The expected bit is 0 after reset and flips whenever the read pointer wraps. `cons_pop` advances the read pointer only while `cons_fresh` is high. `cons_tag_addr` is the address of word 24 of the record at the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_start | input | 1 | Execution of the next command begins |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion can be accepted |
| cpl_cmd_num | input | 16 | Command number of the completion |
| cpl_result | input | 2 | Result code of the completion |
| time_now | input | 32 | Free-running timestamp |
| mem_valid | output | 1 | Memory write word valid |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 32 | Word data of the write |
| head_ptr | output | HEAD_W | Ring slot of the next record |
| irq | output | 1 | One-cycle pulse per finished record |
| cons_pop | input | 1 | Consumer finished the record at its read pointer |
| cons_tag_lsb | input | 1 | Bit 28 of the word at cons_tag_addr |
| cons_tag_addr | output | ADDR_W | Address of the tag word the consumer should read |
| cons_rd_ptr | output | HEAD_W | Consumer read slot |
| cons_fresh | output | 1 | Record at the read pointer is new |

## Verification
A faulty wrap counter stays hidden until the head pointer wraps, so the run must cover more than sixteen passes. With four slots, a tag that misses an increment or wraps at the wrong value shows in word 24 of the first record of the next pass. It also flips the checker's fresh flag for that slot. A wrong word index or head value puts data at a wrong address, and the slot comparison catches it as soon as that record's interrupt fires. Timer faults show in bits [25:16] of word 0 of the same record, and the saturation case needs a run of more than 4092 cycles.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 25;
  localparam int TAG_W       = 4;
  localparam int DUR_W       = 10;
  localparam int CMD_W       = 16;
  localparam int RES_W       = 2;

  typedef enum logic [RES_W-1:0] {
    RES_OK      = 2'd0,
    RES_BLOCKED = 2'd1,
    RES_FAILED  = 2'd2,
    RES_RSRC    = 2'd3
  } result_e;

  function automatic logic [WORD_W-1:0] pack_hdr0(
    input logic [CMD_W-1:0] cmd,
    input logic [DUR_W-1:0] dur,
    input logic [RES_W-1:0] res);
    return {4'b0000, res, dur, cmd};
  endfunction
endpackage

// File: rtl/srp_exec_timer.sv
module srp_exec_timer #(
  parameter int CYC_PER_US = 4,
  parameter int DUR_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [DUR_W-1:0] dur_us
);
  localparam int PW = $clog2(CYC_PER_US + 1);
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  logic [PW-1:0] presc;
  logic          running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc   <= '0;
      dur_us  <= '0;
      running <= 1'b0;
    end else if (start) begin
      presc   <= '0;
      dur_us  <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (presc == PW'(CYC_PER_US - 1)) begin
        presc <= '0;
        if (dur_us != DUR_MAX) dur_us <= dur_us + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  // R3: once saturated, the count holds until a new start
  assert_dur_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_us == DUR_MAX && !start) |=> dur_us == DUR_MAX);
  // R3: the count never moves by more than one per cycle
  assert_dur_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (dur_us == $past(dur_us) || dur_us == $past(dur_us) + 1'b1));
endmodule

// File: rtl/srp_ring_ptr.sv
module srp_ring_ptr #(
  parameter int ENTRIES = 4,
  parameter int LOOP_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  output logic [$clog2(ENTRIES)-1:0] ptr,
  output logic [LOOP_W-1:0]          loop
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      loop <= '0;
    end else if (adv) begin
      if (ptr == LAST) begin
        ptr  <= '0;
        loop <= loop + LOOP_W'(1);
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R5 (producer tag) / R10 (consumer expected bit): wrap bumps the pass counter
  assert_wrap_bumps_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> (ptr == '0 && loop == $past(loop) + LOOP_W'(1)));
  // R6: without an advance the pointer and counter hold
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(ptr) && $stable(loop)));
endmodule

// File: rtl/srp_entry_writer.sv
module srp_entry_writer
  import srp_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpl_valid,
  output logic                       cpl_ready,
  input  logic [CMD_W-1:0]           cpl_cmd_num,
  input  logic [RES_W-1:0]           cpl_result,
  input  logic [DUR_W-1:0]           dur_us,
  input  logic [WORD_W-1:0]          time_now,
  input  logic [$clog2(ENTRIES)-1:0] head,
  input  logic [TAG_W-1:0]           tag,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [WORD_W-1:0]          mem_wdata,
  output logic                       entry_done,
  output logic                       irq
);
  localparam int IDX_W = $clog2(ENTRY_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_WORDS - 1);
  localparam logic [ADDR_W-1:0] RING_END = ADDR_W'(BASE_ADDR + ENTRIES * ENTRY_WORDS);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] hdr0_q, ts_q;
  logic              accept, fire;

  assign cpl_ready  = !busy;
  assign accept     = cpl_valid && !busy;
  assign mem_valid  = busy;
  assign fire       = busy && mem_ready;
  assign entry_done = fire && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      hdr0_q <= '0;
      ts_q   <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= entry_done;
      if (accept) begin
        busy   <= 1'b1;
        idx    <= '0;
        hdr0_q <= pack_hdr0(cpl_cmd_num, dur_us, cpl_result);
      end else if (fire) begin
        if (idx == '0) ts_q <= time_now;
        if (idx == LAST_IDX) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  assign mem_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(head) * ADDR_W'(ENTRY_WORDS) + ADDR_W'(idx);

  always_comb begin
    unique case (idx)
      IDX_W'(0): mem_wdata = hdr0_q;
      IDX_W'(1): mem_wdata = ts_q;
      LAST_IDX:  mem_wdata = {tag, {(WORD_W - TAG_W){1'b0}}};
      default:   mem_wdata = '0;
    endcase
  end

  // R8: a stalled word keeps its address and data
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));
  // R8: an accepted completion starts a write and closes the handshake
  assert_accept_starts_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready) |=> (mem_valid && !cpl_ready));
  // R7: the interrupt is a single-cycle pulse
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R1: every write lands inside the ring
  assert_addr_in_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr >= ADDR_W'(BASE_ADDR) && mem_addr < RING_END));
endmodule

// File: rtl/srp_tag_checker.sv
module srp_tag_checker
  import srp_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pop,
  input  logic                       tag_lsb,
  output logic [ADDR_W-1:0]          tag_addr,
  output logic [$clog2(ENTRIES)-1:0] rd_ptr,
  output logic                       fresh
);
  logic exp_bit;

  srp_ring_ptr #(.ENTRIES(ENTRIES), .LOOP_W(1)) u_rd (
    .clk(clk), .rst_n(rst_n), .adv(pop && fresh), .ptr(rd_ptr), .loop(exp_bit)
  );

  assign fresh    = (tag_lsb == exp_bit);
  assign tag_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(rd_ptr) * ADDR_W'(ENTRY_WORDS)
                  + ADDR_W'(ENTRY_WORDS - 1);

  // R10: popping a stale record does not move the read pointer
  assert_stale_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !fresh) |=> $stable(rd_ptr));
endmodule

// File: rtl/status_ring_producer.sv
module status_ring_producer
  import srp_pkg::*;
#(
  parameter int RING_ENTRIES = 4,
  parameter int CYC_PER_US   = 4,
  parameter int ADDR_W       = 16,
  parameter int BASE_ADDR    = 256,
  localparam int HEAD_W      = $clog2(RING_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_start,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [15:0]       cpl_cmd_num,
  input  logic [1:0]        cpl_result,
  input  logic [31:0]       time_now,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [HEAD_W-1:0] head_ptr,
  output logic              irq,
  input  logic              cons_pop,
  input  logic              cons_tag_lsb,
  output logic [ADDR_W-1:0] cons_tag_addr,
  output logic [HEAD_W-1:0] cons_rd_ptr,
  output logic              cons_fresh
);
  logic [DUR_W-1:0] dur_us;
  logic [TAG_W-1:0] tag;
  logic             entry_done;

  srp_exec_timer #(.CYC_PER_US(CYC_PER_US), .DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(exec_start), .dur_us(dur_us)
  );

  srp_ring_ptr #(.ENTRIES(RING_ENTRIES), .LOOP_W(TAG_W)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(entry_done), .ptr(head_ptr), .loop(tag)
  );

  srp_entry_writer #(.ENTRIES(RING_ENTRIES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_writer (
    .clk(clk), .rst_n(rst_n),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_cmd_num(cpl_cmd_num), .cpl_result(cpl_result),
    .dur_us(dur_us), .time_now(time_now), .head(head_ptr), .tag(tag),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .entry_done(entry_done), .irq(irq)
  );

  srp_tag_checker #(.ENTRIES(RING_ENTRIES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_check (
    .clk(clk), .rst_n(rst_n), .pop(cons_pop), .tag_lsb(cons_tag_lsb),
    .tag_addr(cons_tag_addr), .rd_ptr(cons_rd_ptr), .fresh(cons_fresh)
  );

  // R6: the head moves exactly when a record finishes, seen one cycle later as irq
  assert_head_moves_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (head_ptr != $past(head_ptr)));
endmodule

// File: tb/status_ring_producer_tb.sv
module status_ring_producer_tb;
  localparam int RING = 4;
  localparam int CYC  = 4;
  localparam int AW   = 16;
  localparam int BASE = 256;
  localparam int EW   = 25;
  localparam int NCMD = 70;

  logic clk = 0, rst_n = 0;
  logic exec_start = 0, cpl_valid = 0, mem_ready = 0, cons_pop = 0;
  logic [15:0] cpl_cmd_num = 0;
  logic [1:0]  cpl_result = 0;
  logic [31:0] time_now = 0;
  logic cpl_ready, mem_valid, irq, cons_fresh, cons_tag_lsb;
  logic [AW-1:0] mem_addr, cons_tag_addr;
  logic [31:0] mem_wdata;
  logic [1:0] head_ptr, cons_rd_ptr;

  always #2.5 clk = ~clk;

  status_ring_producer #(.RING_ENTRIES(RING), .CYC_PER_US(CYC), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_cmd_num(cpl_cmd_num), .cpl_result(cpl_result), .time_now(time_now),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .head_ptr(head_ptr), .irq(irq), .cons_pop(cons_pop), .cons_tag_lsb(cons_tag_lsb),
    .cons_tag_addr(cons_tag_addr), .cons_rd_ptr(cons_rd_ptr), .cons_fresh(cons_fresh)
  );

  // memory model, prefilled so every tag LSB starts at 1
  logic [31:0] mem [RING*EW];
  int cyc = 0, start_cyc = 0;
  logic [31:0] exp_hdr0 = 0, exp_ts = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  assign cons_tag_lsb = mem[int'(cons_tag_addr) - BASE][28];

  function automatic logic [31:0] exp_hdr(input logic [15:0] c, input int d, input logic [1:0] r);
    int us = (d - 1) / CYC;
    if (us > 1023) us = 1023;
    return {4'b0, r, 10'(us), c};
  endfunction

  function automatic logic [31:0] exp_word(input int i, input logic [31:0] h0, input logic [31:0] ts, input int n);
    if (i == 0) return h0;
    if (i == 1) return ts;
    if (i == EW - 1) return {4'((n / RING) % 16), 28'b0};
    return 32'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (exec_start) start_cyc = cyc;
    if (cpl_valid && cpl_ready) exp_hdr0 = exp_hdr(cpl_cmd_num, cyc - start_cyc, cpl_result);
    if (mem_valid && mem_ready) begin
      mem[int'(mem_addr) - BASE] <= mem_wdata;
      if ((int'(mem_addr) - BASE) % EW == 0) exp_ts = time_now;
    end
  end

  always @(negedge clk) begin
    time_now  <= 32'hA500_0000 + 32'(cyc) * 3;
    mem_ready <= ($urandom_range(0, 9) < 7);
  end

  task automatic run_cmd(input int d, input logic [15:0] c, input logic [1:0] r, input bit bp_probe);
    @(negedge clk); exec_start = 1;
    @(negedge clk); exec_start = 0;
    repeat (d - 1) @(negedge clk);
    cpl_valid = 1; cpl_cmd_num = c; cpl_result = r;
    @(negedge clk); cpl_valid = 0;
    if (bp_probe) begin
      cpl_valid = 1; cpl_cmd_num = ~c;
      for (int k = 0; k < 5; k++) begin
        check("R8 cpl_ready low while writing", 32'(cpl_ready), 32'd0);
        @(negedge clk);
      end
      cpl_valid = 0;
    end
    while (!irq) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < RING * EW; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 cpl_ready", 32'(cpl_ready), 32'd1);
    check("R9 mem_valid", 32'(mem_valid), 32'd0);
    check("R9 irq", 32'(irq), 32'd0);
    check("R9 head_ptr", 32'(head_ptr), 32'd0);
    check("R9 cons_rd_ptr", 32'(cons_rd_ptr), 32'd0);
    check("R10 stale after reset", 32'(cons_fresh), 32'd0);
    check("R10 tag addr", 32'(cons_tag_addr), 32'(BASE + EW - 1));
    for (int n = 0; n < NCMD; n++) begin
      int d;
      logic [15:0] c;
      logic [1:0] r;
      int slot;
      d = $urandom_range(2, 40);
      if (n == 3) d = 1;
      if (n == 5) d = 4200;      // R3 saturation
      if (n == 7) d = CYC + 1;   // R3 first whole microsecond
      c = 16'($urandom);
      r = (n < 4) ? 2'(n) : 2'($urandom_range(0, 3));
      slot = n % RING;
      run_cmd(d, c, r, n == 10);
      // irq observed here; next cycle must be low (R7)
      @(negedge clk);
      check("R7 irq single cycle", 32'(irq), 32'd0);
      check("R6 head advance", 32'(head_ptr), 32'((n + 1) % RING));
      for (int i = 0; i < EW; i++) begin
        string tg;
        tg = (i == 0) ? "R2/R3 word0" : (i == 1) ? "R4 word1" : (i == EW - 1) ? "R5 word24" : "R1 reserved";
        check(tg, mem[slot * EW + i], exp_word(i, exp_hdr0, exp_ts, n));
      end
      check("R10 fresh record", 32'(cons_fresh), 32'd1);
      check("R10 rd_ptr", 32'(cons_rd_ptr), 32'(slot));
      cons_pop = 1; @(negedge clk); cons_pop = 0;
      check("R10 pop advances", 32'(cons_rd_ptr), 32'((n + 1) % RING));
      check("R10 next is stale", 32'(cons_fresh), 32'd0);
      cons_pop = 1; @(negedge clk); cons_pop = 0;
      check("R10 stale pop ignored", 32'(cons_rd_ptr), 32'((n + 1) % RING));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule